// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and a 128K x 8 asynchronous static RAM. The host hands it one read or one write at a time over a valid/ready request channel. The block turns each request into the memory's asynchronous control waveforms. Those waveforms are an active-low and an active-high chip enable, an active-low write enable and an active-low output enable. The block also drives the 17-bit address and controls the data bus through a separate output value, output enable and input value. A read returns its byte through a single-cycle response pulse.

The memory stores a byte only while all three write conditions overlap: the active-low enable is low, the active-high enable is high and write enable is low. The byte is latched on the edge that ends this overlap, so the data must be settled some time before that edge. The block drops write enable and both chip enables on the same clock edge. Its data driver turns on a programmable number of cycles after write enable falls, and it stays on for a programmable number of cycles after the write ends.

A per-request mode bit picks one of two write styles. In one, output enable is held high. In the other, output enable stays low and write enable alone controls the write. Every strobe width and gap is a parameter counted in clock cycles.

Top module: `sram_ctl`

## Requirements
- R1: After reset, mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, rsp_valid=0 and req_ready=1, and they stay that way until a request is accepted.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. A req_valid pulse while req_ready is 0 has no effect on memory contents.
- R3: For a read, the chip enables are asserted and mem_oe_n is 0 (mem_we_n 1) for RD_CYC cycles starting at the accept edge. mem_dq_in is captured on the edge that ends this strobe. rsp_valid is 1 for exactly the following cycle, with the captured byte on rsp_rdata.
- R4: For a write, mem_we_n is 0 with both chip enables asserted for exactly WE_CYC = max(WR_PULSE, WR_TURN+WR_SETUP) cycles. mem_addr is stable throughout, and write enable and the chip enables end on the same edge.
- R5: mem_dq_oe is 0 during the first WR_TURN cycles of the write strobe. It stays 1 for WR_HOLD cycles after the write ends. It is never 1 while the memory could drive (mem_oe_n=0 with mem_we_n=1), nor while the block is idle.
- R6: The data driver is on for at least WR_SETUP consecutive cycles before the edge that ends the write, with the write byte on mem_dq_out.
- R7: With req_wr_oe_low=1 at acceptance, mem_oe_n is 0 for the whole write strobe. With req_wr_oe_low=0, mem_oe_n is 1 during the write. It is 1 after the strobe ends in both cases.
- R8: req_ready returns to 1 exactly RD_CYC+GAP cycles after a read is accepted and WE_CYC+WR_HOLD+GAP cycles after a write is accepted, and is 0 in between.
- R9: A read returns the byte most recently written to the same address, at any address including 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, may accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wr_oe_low | input | 1 | Write style: 1 keeps output enable low during the write |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read byte |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DW | Value for the data bus driver |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | DW | Value seen on the data bus |

## Verification
The bench models the memory. The model stores a byte only when the write overlap ends, and it flags any write where the driver was on for too few cycles before that end. A design that turned the driver off on the same edge as write enable, or one that shortened the write pulse, would therefore lose or corrupt bytes, and the read-back of the boundary addresses would expose it.

The model also drives the bus during reads and reports contention. This catches a driver left on into a read, and also a driver enabled before the turnaround in the mode that keeps output enable low. A write pulse sent while the block is busy must leave memory unchanged, and ready must rise on the exact cycle given for each kind of access; a design that took the early pulse or let ready rise early would fail these checks.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_HOLD,
    ST_GAP
  } seq_st_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != {CW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rdata
);

  // Address and write byte are latched once per request and held for the
  // whole access, so address setup and hold around the strobe are met.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (load) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (cap) begin
      rdata <= mem_dq_in;
    end
  end

  // The address may change only on an accept, which needs an idle block.
  p_addr_hold_r4 : assert property (@(posedge clk) disable iff (rst)
    (load && mem_addr != req_addr) |=> (mem_addr == $past(req_addr)));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int WE_CYC  = 3,
  parameter int WR_TURN = 1,
  parameter int WR_HOLD = 1,
  parameter int GAP     = 1,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          req_wr_oe_low,
  input  logic [CW-1:0] cnt,
  output logic          accept,
  output logic          cnt_clr,
  output logic          cap,
  output logic          ready,
  output logic          rvalid,
  output logic          ce_n,
  output logic          ce,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);

  seq_st_t state;
  logic    last;
  logic    turn_hit;

  assign accept = ready && req_valid;

  always_comb begin
    case (state)
      ST_RD:   last = (cnt == CW'(RD_CYC - 1));
      ST_WR:   last = (cnt == CW'(WE_CYC - 1));
      ST_HOLD: last = (cnt == CW'(WR_HOLD - 1));
      ST_GAP:  last = (cnt == CW'(GAP - 1));
      default: last = 1'b0;
    endcase
  end

  generate
    if (WR_TURN == 0) begin : g_turn_now
      assign turn_hit = 1'b0;
    end else begin : g_turn_cnt
      assign turn_hit = (state == ST_WR) && (cnt == CW'(WR_TURN - 1));
    end
  endgenerate

  assign cnt_clr = accept || last;
  assign cap     = (state == ST_RD) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ready  <= 1'b1;
      rvalid <= 1'b0;
      ce_n   <= 1'b1;
      ce     <= 1'b0;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      dq_oe  <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ready <= 1'b0;
            ce_n  <= 1'b0;
            ce    <= 1'b1;
            if (req_we) begin
              we_n  <= 1'b0;
              oe_n  <= !req_wr_oe_low;
              dq_oe <= (WR_TURN == 0);
              state <= ST_WR;
            end else begin
              oe_n  <= 1'b0;
              state <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (last) begin
            rvalid <= 1'b1;
            ce_n   <= 1'b1;
            ce     <= 1'b0;
            oe_n   <= 1'b1;
            state  <= ST_GAP;
          end
        end
        ST_WR: begin
          if (turn_hit) dq_oe <= 1'b1;
          if (last) begin
            we_n  <= 1'b1;
            ce_n  <= 1'b1;
            ce    <= 1'b0;
            oe_n  <= 1'b1;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (last) begin
            dq_oe <= 1'b0;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (last) begin
            ready <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (rst)
    ready |-> (ce_n && !ce && we_n && oe_n && !dq_oe));

  p_busy_after_take_r2 : assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);

  p_rvalid_pulse_r3 : assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  p_we_in_chip_r4 : assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && ce));

  p_we_ends_chip_r4 : assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (ce_n && !ce));

  p_no_contention_r5 : assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (oe_n || !we_n));

  p_drive_past_end_r5 : assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> dq_oe);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int RD_CYC   = 3,
  parameter int WR_TURN  = 1,
  parameter int WR_SETUP = 2,
  parameter int WR_PULSE = 3,
  parameter int WR_HOLD  = 1,
  parameter int GAP      = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic          req_wr_oe_low,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int WE_CYC = imax(WR_PULSE, WR_TURN + WR_SETUP);
  localparam int LONGEST = imax(imax(RD_CYC, WE_CYC), imax(WR_HOLD, GAP));
  localparam int CW = $clog2(LONGEST + 1);

  logic          accept;
  logic          cnt_clr;
  logic          cap;
  logic [CW-1:0] cnt;

  sram_ctl_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .cnt (cnt)
  );

  sram_ctl_seq #(
    .RD_CYC  (RD_CYC),
    .WE_CYC  (WE_CYC),
    .WR_TURN (WR_TURN),
    .WR_HOLD (WR_HOLD),
    .GAP     (GAP),
    .CW      (CW)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_we        (req_we),
    .req_wr_oe_low (req_wr_oe_low),
    .cnt           (cnt),
    .accept        (accept),
    .cnt_clr       (cnt_clr),
    .cap           (cap),
    .ready         (req_ready),
    .rvalid        (rsp_valid),
    .ce_n          (mem_ce_n),
    .ce            (mem_ce),
    .we_n          (mem_we_n),
    .oe_n          (mem_oe_n),
    .dq_oe         (mem_dq_oe)
  );

  sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cap        (cap),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rdata      (rsp_rdata)
  );

  // Address stays put from one write-strobe cycle to the next.
  p_addr_steady_r4 : assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RD_CYC = 3;
  localparam int WR_TURN = 1;
  localparam int WR_SETUP = 2;
  localparam int WR_PULSE = 3;
  localparam int WR_HOLD = 1;
  localparam int GAP = 1;
  localparam int WE_CYC = (WR_PULSE > WR_TURN + WR_SETUP) ? WR_PULSE : WR_TURN + WR_SETUP;
  localparam int T_RD = RD_CYC + GAP;
  localparam int T_WR = WE_CYC + WR_HOLD + GAP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic          req_wr_oe_low = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  int n_chk = 0;
  int n_err = 0;
  bit cur_mode = 1'b0;
  bit done = 1'b0;

  logic [DW-1:0] model  [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];
  logic [AW-1:0] pool [16];

  always #10 clk = ~clk;

  sram_ctl #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_TURN(WR_TURN), .WR_SETUP(WR_SETUP),
    .WR_PULSE(WR_PULSE), .WR_HOLD(WR_HOLD), .GAP(GAP)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_wr_oe_low(req_wr_oe_low), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  // Memory model: drives during reads, stores at end of write overlap.
  bit            w_act = 1'b0;
  int            w_len, w_setup;
  logic [AW-1:0] w_addr;
  bit            w_addr_bad, w_oe_bad, w_turn_bad;

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit rd_cond = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;
      automatic bit act = !mem_ce_n && mem_ce && !mem_we_n;
      mem_dq_in = (rd_cond && model.exists(mem_addr)) ? model[mem_addr] : '0;
      if (mem_dq_oe && rd_cond) check(1'b0, "R5", "bus contention", 1, 0);
      if (mem_dq_oe && req_ready) check(1'b0, "R5", "driver on while idle", 1, 0);
      if (act) begin
        if (!w_act) begin
          w_act = 1'b1; w_len = 0; w_setup = 0; w_addr = mem_addr;
          w_addr_bad = 1'b0; w_oe_bad = 1'b0; w_turn_bad = 1'b0;
        end
        w_len++;
        if (mem_dq_oe) w_setup++; else w_setup = 0;
        if (w_len <= WR_TURN && mem_dq_oe) w_turn_bad = 1'b1;
        if (mem_addr != w_addr) w_addr_bad = 1'b1;
        if (mem_oe_n != !cur_mode) w_oe_bad = 1'b1;
      end else if (w_act) begin
        w_act = 1'b0;
        check(w_len == WE_CYC, "R4", "write strobe length", w_len, WE_CYC);
        check(!w_addr_bad, "R4", "address moved in strobe", int'(w_addr_bad), 0);
        check(w_setup >= WR_SETUP, "R6", "data setup cycles", w_setup, WR_SETUP);
        check(mem_dq_oe == 1'b1, "R5", "driver hold after end", int'(mem_dq_oe), 1);
        check(!w_turn_bad, "R5", "driver before turnaround", int'(w_turn_bad), 0);
        check(!w_oe_bad && mem_oe_n, "R7", "output enable in write", int'(mem_oe_n), 1);
        model[w_addr] = mem_dq_out;
      end
    end
  end

  // Start at a negedge with ready high; ends at the negedge where ready returns.
  task automatic do_op(input bit wr, input bit mode, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit poke);
    automatic logic [DW-1:0] exp_rd = expect_rd(a);
    automatic int t = wr ? T_WR : T_RD;
    automatic int last = wr ? T_WR : ((T_RD > RD_CYC + 1) ? T_RD : RD_CYC + 1);
    req_valid = 1'b1; req_we = wr; req_wr_oe_low = mode;
    req_addr = a; req_wdata = d; cur_mode = mode;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) shadow[a] = d;
    for (int n = 0; n <= last; n++) begin
      if (poke && n == 1) begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = ~exp_rd;
      end
      if (poke && n == 2) req_valid = 1'b0;
      if (!wr && n == RD_CYC) begin
        check(rsp_valid == 1'b1, "R3", "rvalid at capture", int'(rsp_valid), 1);
        check(rsp_rdata == exp_rd, "R9", "read data", int'(rsp_rdata), int'(exp_rd));
      end
      if (!wr && n == RD_CYC + 1)
        check(rsp_valid == 1'b0, "R3", "rvalid one cycle", int'(rsp_valid), 0);
      if (!wr && n < RD_CYC)
        check(!mem_oe_n && mem_we_n && !mem_ce_n && mem_ce, "R3", "read strobes",
              int'(mem_oe_n), 0);
      if (n == t - 1) check(req_ready == 1'b0, "R8", "ready still low", int'(req_ready), 0);
      if (n == t) check(req_ready == 1'b1, "R8", "ready returns", int'(req_ready), 1);
      if (n < last) @(negedge clk);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1", "strobes in reset", int'({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}), 5'b10110);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && mem_ce_n && !mem_ce && !mem_dq_oe,
          "R1", "idle after reset", int'({req_ready, rsp_valid}), 2'b10);

    // Directed corners
    do_op(1'b1, 1'b0, 17'h00000, 8'hA5, 1'b0);
    do_op(1'b1, 1'b1, 17'h1FFFF, 8'h5A, 1'b0);
    do_op(1'b0, 1'b0, 17'h00000, 8'h00, 1'b0);
    do_op(1'b0, 1'b0, 17'h1FFFF, 8'h00, 1'b0);
    do_op(1'b1, 1'b1, 17'h00000, 8'hFF, 1'b0);
    do_op(1'b0, 1'b0, 17'h00000, 8'h00, 1'b0);
    do_op(1'b1, 1'b0, 17'h00000, 8'h00, 1'b0);
    do_op(1'b0, 1'b0, 17'h00000, 8'h00, 1'b0);
    // R2: write pulse while busy must not land
    do_op(1'b0, 1'b0, 17'h1FFFF, 8'h00, 1'b1);
    do_op(1'b0, 1'b0, 17'h1FFFF, 8'h00, 1'b0);

    // Random traffic over an address pool holding both ends
    pool[0] = 17'h00000;
    pool[1] = 17'h1FFFF;
    for (int i = 2; i < 16; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 16; i++) do_op(1'b1, i[0], pool[i], DW'($urandom), 1'b0);
    for (int i = 0; i < 300; i++) begin
      automatic int k = $urandom % 16;
      do_op(1'($urandom), 1'($urandom), pool[k], DW'($urandom), 1'b0);
    end
    for (int i = 0; i < 16; i++) do_op(1'b0, 1'b0, pool[i], 8'h00, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R8", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule